// File: doc/BRIEF.md
# ATM Cell Transmit Convergence

This block sits between a byte-wide cell source and a serial line framer. It turns a stream of 53-byte ATM cells into a continuous byte stream at the pace the line asks for. Each `line_en` pulse marks one byte slot on the line. In every slot the block either emits one byte of the cell in flight or, when nothing can be sent, leaves the slot empty. For each cell the header check byte is recomputed and replaces whatever the source placed in byte 4, with an optional coset XORed on top. The 48 payload bytes pass through an optional self-synchronizing scrambler.

The rate mode decides how gaps between cells are filled. In internal-rate mode, a boundary slot with no source byte waiting starts an idle cell generated inside the block. In external-rate mode, the source is expected to supply its own fill cells. These pass through the same header-check and scrambling path as any other cell, and a boundary slot without a source byte stays empty. A loopback control routes the transmit stream onto the receive-side outputs in place of the line's receive inputs.

The source side is a valid/ready byte stream. It carries no cell marker, so cells are counted from reset as back-to-back groups of 53 bytes. `in_ready` is raised only in a line slot, and only at a cell boundary or while a source cell is in flight. A source may drop `in_valid` in the middle of a cell. That slot then emits nothing, and the cell resumes with no idle cell inserted. `in_data` matters only in a cycle where both `in_valid` and `in_ready` are high.

Top module: `atm_tc_tx`

## Requirements
- R1: A byte is emitted only in a cycle with `line_en` high. It appears on `out_data` with `out_valid` high in the following cycle. Header bytes 0 to 3 and, with scrambling off, payload bytes 5 to 52 leave unchanged.
- R2: Output byte 4 of every cell is the CRC-8 (generator x^8+x^2+x+1, zero initial value, most significant bit first) of output bytes 0 to 3. The source's own byte 4 is consumed and discarded.
- R3: With `cfg_coset_en` high, the byte-4 check value is XORed with 0x55 before it is sent.
- R4: With `cfg_scramble_en` high, each payload bit (bytes 5 to 52, MSB first) is sent as the input bit XOR the scrambled bit sent 43 payload bits earlier. The scrambler history is zero after reset and is not advanced by header bytes or by payload sent with scrambling off.
- R5: In internal-rate mode (`cfg_internal_rate` high), a boundary slot with `in_valid` low starts an idle cell with header bytes 00 00 00 01, its computed check byte, and 48 payload bytes of 0x6A that are scrambled like any payload.
- R6: In external-rate mode, a boundary slot with `in_valid` low emits nothing, and the next slot is still a boundary.
- R7: A source cell starts only at a boundary. Once started, a slot with `in_valid` low emits nothing, and no idle cell is inserted before its 53 bytes are sent.
- R8: `out_soc` is high together with byte 0 of each cell and low at all other times.
- R9: `in_ready` equals `line_en` AND (at a cell boundary OR in the middle of a source cell). A byte transfers when `in_valid` and `in_ready` are both high.
- R10: With `cfg_loopback` high, `rx_valid`/`rx_data` carry `out_valid`/`out_data`. Otherwise they carry `rx_line_valid`/`rx_line_data`.
- R11: During reset, `out_valid` and `out_soc` are low and `out_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_internal_rate | input | 1 | 1: block generates idle cells; 0: source supplies fill |
| cfg_scramble_en | input | 1 | Enable payload scrambling |
| cfg_coset_en | input | 1 | XOR 0x55 onto the header check byte |
| cfg_loopback | input | 1 | Route transmit stream to receive outputs |
| line_en | input | 1 | One line byte slot this cycle |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Block takes the source byte this cycle |
| in_data | input | 8 | Source byte |
| out_valid | output | 1 | Line byte valid |
| out_data | output | 8 | Line byte |
| out_soc | output | 1 | Byte 0 of a cell |
| rx_line_valid | input | 1 | Receive byte valid from the line |
| rx_line_data | input | 8 | Receive byte from the line |
| rx_valid | output | 1 | Receive byte valid toward the receive side |
| rx_data | output | 8 | Receive byte toward the receive side |

## Verification
The properties place no constraint on the source. `in_valid` may rise and fall in any cycle, and the cell count starts at reset, so they hold for any handshake pattern. They do take for granted that reset leaves the block at a cell boundary, and that a cell's origin (source or fill) can be judged from the handshake one cycle before its first output byte. The stimulus drops `in_valid` at random points inside cells and thins `line_en` to every second or third cycle. It also changes the rate mode while a cell is in flight and drives the receive-line inputs at random, so every one of these cases occurs while the properties are watched.

// File: rtl/atm_tc_pkg.sv
package atm_tc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {SRC_NONE, SRC_USER, SRC_IDLE} cell_src_e;

  // One byte of a bitwise CRC-8, MSB first, with the given generator (x^8 implied).
  function automatic byte_t crc8_step(input byte_t crc_in, input byte_t d, input byte_t poly);
    byte_t c;
    logic  fb;
    c = crc_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[BYTE_W-1] ^ d[i];
      c  = {c[BYTE_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/atm_tc_cell_seq.sv
module atm_tc_cell_seq
  import atm_tc_pkg::*;
#(
  parameter int unsigned CELL_LEN  = 53,
  parameter logic [31:0] IDLE_HDR  = 32'h0000_0001,
  parameter byte_t       IDLE_FILL = 8'h6A,
  localparam int unsigned PW = $clog2(CELL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_en,
  input  logic          internal_rate,
  input  logic          in_valid,
  input  byte_t         in_data,
  output logic          in_ready,
  output logic          emit,
  output logic [PW-1:0] pos,
  output byte_t         raw
);
  logic [PW-1:0] pos_q;
  cell_src_e     src_q;
  logic          at_bound, take_user, start_idle, cont_idle, idle_now;
  logic [31:0]   hdr_shift;

  always_comb begin
    at_bound   = (pos_q == '0);
    in_ready   = line_en && (at_bound || src_q == SRC_USER);
    take_user  = in_ready && in_valid;
    start_idle = line_en && at_bound && !in_valid && internal_rate;
    cont_idle  = line_en && !at_bound && (src_q == SRC_IDLE);
    emit       = take_user || start_idle || cont_idle;
    idle_now   = start_idle || cont_idle;
    hdr_shift  = IDLE_HDR << (BYTE_W * pos_q[1:0]);
    if (!idle_now)
      raw = in_data;
    else if (pos_q < PW'(4))
      raw = hdr_shift[31 -: BYTE_W];
    else
      raw = IDLE_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      src_q <= SRC_NONE;
    end else if (emit) begin
      if (pos_q == PW'(CELL_LEN - 1)) begin
        pos_q <= '0;
        src_q <= SRC_NONE;
      end else begin
        pos_q <= pos_q + 1'b1;
        if (at_bound) src_q <= take_user ? SRC_USER : SRC_IDLE;
      end
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/atm_tc_hec.sv
module atm_tc_hec
  import atm_tc_pkg::*;
#(
  parameter byte_t POLY = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd,
  input  logic  restart,
  input  byte_t din,
  output byte_t crc
);
  byte_t crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      crc_q <= '0;
    else if (upd)
      crc_q <= crc8_step(restart ? '0 : crc_q, din, POLY);
  end

  assign crc = crc_q;
endmodule

// File: rtl/atm_tc_scrambler.sv
module atm_tc_scrambler
  import atm_tc_pkg::*;
#(
  parameter int unsigned LAG = 43
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  byte_t din,
  output byte_t dout
);
  // hist[0] is the newest scrambled bit; hist[LAG-1] the oldest kept.
  logic [LAG-1:0] hist;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    // Bit b leaves at order BYTE_W-1-b within the byte; its partner is LAG bits older.
    assign dout[b] = din[b] ^ hist[LAG - BYTE_W + b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hist <= '0;
    else if (adv)
      hist <= {hist[LAG-BYTE_W-1:0], dout};
  end
endmodule

// File: rtl/atm_tc_tx.sv
module atm_tc_tx
  import atm_tc_pkg::*;
#(
  parameter int unsigned CELL_LEN  = 53,
  parameter int unsigned HDR_LEN   = 5,
  parameter int unsigned SCR_LAG   = 43,
  parameter logic [7:0]  CRC_POLY  = 8'h07,
  parameter logic [7:0]  COSET_PAT = 8'h55,
  parameter logic [7:0]  IDLE_FILL = 8'h6A,
  parameter logic [31:0] IDLE_HDR  = 32'h0000_0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_internal_rate,
  input  logic       cfg_scramble_en,
  input  logic       cfg_coset_en,
  input  logic       cfg_loopback,
  input  logic       line_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_soc,
  input  logic       rx_line_valid,
  input  logic [7:0] rx_line_data,
  output logic       rx_valid,
  output logic [7:0] rx_data
);
  localparam int unsigned PW = $clog2(CELL_LEN);

  logic          emit;
  logic [PW-1:0] pos;
  byte_t         raw, hec_q, scr_out, byte_sel;
  logic          is_hdr, is_hec, is_pay;

  atm_tc_cell_seq #(
    .CELL_LEN (CELL_LEN),
    .IDLE_HDR (IDLE_HDR),
    .IDLE_FILL(IDLE_FILL)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_en      (line_en),
    .internal_rate(cfg_internal_rate),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .emit         (emit),
    .pos          (pos),
    .raw          (raw)
  );

  always_comb begin
    is_hdr = (pos < PW'(HDR_LEN - 1));
    is_hec = (pos == PW'(HDR_LEN - 1));
    is_pay = !is_hdr && !is_hec;
  end

  atm_tc_hec #(.POLY(CRC_POLY)) u_hec (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (emit && is_hdr),
    .restart(pos == '0),
    .din    (raw),
    .crc    (hec_q)
  );

  atm_tc_scrambler #(.LAG(SCR_LAG)) u_scr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (emit && is_pay && cfg_scramble_en),
    .din  (raw),
    .dout (scr_out)
  );

  always_comb begin
    if (is_hdr)
      byte_sel = raw;
    else if (is_hec)
      byte_sel = hec_q ^ (cfg_coset_en ? COSET_PAT : 8'h00);
    else
      byte_sel = cfg_scramble_en ? scr_out : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      out_soc   <= emit && (pos == '0);
      if (emit) out_data <= byte_sel;
    end
  end

  always_comb begin
    rx_valid = cfg_loopback ? out_valid : rx_line_valid;
    rx_data  = cfg_loopback ? out_data  : rx_line_data;
  end
endmodule

// File: rtl/atm_tc_tx_chk.sv
module atm_tc_tx_chk #(
  parameter int unsigned CELL_LEN = 53
) (
  input logic clk,
  input logic rst_n,
  input logic line_en,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_internal_rate,
  input logic out_valid,
  input logic out_soc
);
  localparam int unsigned CW = $clog2(CELL_LEN);

  logic [CW-1:0] cnt;
  logic          le_q, hs_q, int_q, user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      le_q   <= 1'b0;
      hs_q   <= 1'b0;
      int_q  <= 1'b0;
      user_q <= 1'b0;
    end else begin
      le_q  <= line_en;
      hs_q  <= in_valid && in_ready;
      int_q <= cfg_internal_rate;
      if (out_valid) cnt <= (cnt == CW'(CELL_LEN - 1)) ? '0 : cnt + 1'b1;
      if (out_valid && out_soc) user_q <= hs_q;
    end
  end

  assert_emit_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> le_q);

  assert_ready_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> line_en);

  assert_soc_on_cell_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_soc == (cnt == '0)));

  assert_soc_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);

  assert_ext_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_soc && !int_q) |-> hs_q);

  assert_user_cell_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_soc && user_q) |-> hs_q);
endmodule

bind atm_tc_tx atm_tc_tx_chk #(.CELL_LEN(CELL_LEN)) u_atm_tc_tx_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .line_en          (line_en),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .cfg_internal_rate(cfg_internal_rate),
  .out_valid        (out_valid),
  .out_soc          (out_soc)
);

// File: tb/test_atm_tc_tx.sv
module test_atm_tc_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_internal_rate = 1'b0, cfg_scramble_en = 1'b0, cfg_coset_en = 1'b0, cfg_loopback = 1'b0;
  logic       line_en = 1'b0, in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_soc;
  logic [7:0] out_data;
  logic       rx_line_valid = 1'b0;
  logic [7:0] rx_line_data = 8'h00;
  logic       rx_valid;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  atm_tc_tx i_atm_tc_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_internal_rate(cfg_internal_rate), .cfg_scramble_en(cfg_scramble_en),
    .cfg_coset_en(cfg_coset_en), .cfg_loopback(cfg_loopback),
    .line_en(line_en), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_soc(out_soc),
    .rx_line_valid(rx_line_valid), .rx_line_data(rx_line_data),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Phase knobs, applied to the ports inside the cycle task.
  bit p_int, p_scr, p_cos, p_lb;
  int le_div, gap_pct, push_pct;

  // Behavioural model state.
  logic [7:0] src_q[$];
  int         m_pos = 0, m_src = 0;   // 0 none, 1 source cell, 2 idle cell
  logic [7:0] m_hdr[4];
  bit         m_hist[$];
  logic       e_valid = 0, e_soc = 0;
  logic [7:0] e_data = 0;
  string      e_tag = "R1", v_tag = "R1";

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  function automatic logic [7:0] ref_scramble(input logic [7:0] d);
    logic [7:0] o;
    bit         fb;
    for (int b = 7; b >= 0; b--) begin
      fb   = (m_hist.size() >= 43) ? m_hist[m_hist.size() - 43] : 1'b0;
      o[b] = d[b] ^ fb;
      m_hist.push_back(o[b]);
      if (m_hist.size() > 43) void'(m_hist.pop_front());
    end
    return o;
  endfunction

  task automatic push_cell();
    for (int k = 0; k < 53; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (k == 0) v = v | 8'h10;   // never an idle header
      src_q.push_back(v);
    end
  endtask

  task automatic model_step(output logic rdy);
    bit         bnd, take, emit, idle;
    logic [7:0] raw, ob;
    int         p;
    bnd  = (m_pos == 0);
    p    = m_pos;
    rdy  = line_en && (bnd || m_src == 1);
    take = rdy && in_valid;
    emit = 0;
    raw  = in_data;
    v_tag = bnd ? (cfg_internal_rate ? "R5" : "R6") : "R7";
    if (take) begin
      emit = 1;
      if (bnd) m_src = 1;
      void'(src_q.pop_front());
    end else if (line_en && bnd && cfg_internal_rate) begin
      emit = 1;
      m_src = 2;
    end else if (line_en && !bnd && m_src == 2) begin
      emit = 1;
    end
    idle = emit && (m_src == 2);
    if (idle) raw = (p < 3) ? 8'h00 : (p == 3) ? 8'h01 : 8'h6A;
    ob = e_data;
    if (emit) begin
      if (p < 4) begin
        m_hdr[p] = raw;
        ob = raw;
        e_tag = idle ? "R5" : "R1";
      end else if (p == 4) begin
        ob = ref_hec({m_hdr[0], m_hdr[1], m_hdr[2], m_hdr[3]}) ^ (cfg_coset_en ? 8'h55 : 8'h00);
        e_tag = cfg_coset_en ? "R3" : "R2";
      end else begin
        ob = cfg_scramble_en ? ref_scramble(raw) : raw;
        e_tag = cfg_scramble_en ? "R4" : (idle ? "R5" : "R1");
      end
      if (m_pos == 52) begin
        m_pos = 0;
        m_src = 0;
      end else begin
        m_pos++;
      end
    end
    e_valid = emit;
    e_soc   = emit && (p == 0);
    e_data  = ob;
  endtask

  task automatic cycle();
    logic exp_rdy;
    @(negedge clk);
    chk(v_tag, "out_valid", {7'b0, out_valid}, {7'b0, e_valid});
    if (e_valid) begin
      chk(e_tag, "out_data", out_data, e_data);
      chk("R8", "out_soc", {7'b0, out_soc}, {7'b0, e_soc});
    end else begin
      chk("R8", "out_soc idle slot", {7'b0, out_soc}, 8'h00);
    end
    if (cfg_loopback) begin
      chk("R10", "rx_valid loop", {7'b0, rx_valid}, {7'b0, e_valid});
      if (e_valid) chk("R10", "rx_data loop", rx_data, e_data);
    end else begin
      chk("R10", "rx_valid line", {7'b0, rx_valid}, {7'b0, rx_line_valid});
      chk("R10", "rx_data line", rx_data, rx_line_data);
    end
    // Drive the next cycle's inputs.
    cfg_internal_rate = p_int;
    cfg_scramble_en   = p_scr;
    cfg_coset_en      = p_cos;
    cfg_loopback      = p_lb;
    if (src_q.size() < 106 && $urandom_range(99) < push_pct) push_cell();
    line_en  = (le_div <= 1) ? 1'b1 : ($urandom_range(le_div - 1) == 0);
    in_valid = (src_q.size() > 0) && ($urandom_range(99) >= gap_pct);
    in_data  = (src_q.size() > 0) ? src_q[0] : 8'($urandom);
    rx_line_valid = 1'($urandom);
    rx_line_data  = 8'($urandom);
    #1;
    model_step(exp_rdy);
    chk("R9", "in_ready", {7'b0, in_ready}, {7'b0, exp_rdy});
  endtask

  task automatic run_phase(bit i_r, bit s_r, bit c_r, bit l_r, int div, int gap, int push, int n);
    p_int = i_r; p_scr = s_r; p_cos = c_r; p_lb = l_r;
    le_div = div; gap_pct = gap; push_pct = push;
    for (int c = 0; c < n; c++) cycle();
  endtask

  initial begin
    p_int = 1; p_scr = 0; p_cos = 0; p_lb = 0;
    le_div = 1; gap_pct = 0; push_pct = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      line_en  = 1'b1;
      in_valid = 1'b1;
      chk("R11", "out_valid in reset", {7'b0, out_valid}, 8'h00);
      chk("R11", "out_soc in reset", {7'b0, out_soc}, 8'h00);
      chk("R11", "out_data in reset", out_data, 8'h00);
    end
    @(negedge clk);
    line_en  = 1'b0;
    in_valid = 1'b0;
    rst_n    = 1'b1;
    // internal fill, plain; then scrambled with coset
    run_phase(1, 0, 0, 0, 1, 0, 2, 800);
    run_phase(1, 1, 1, 0, 1, 0, 3, 800);
    // thinned line, mid-cell gaps, loopback on
    run_phase(1, 1, 0, 1, 3, 20, 3, 1200);
    // external rate with gaps
    run_phase(0, 1, 1, 0, 2, 10, 3, 1200);
    run_phase(0, 0, 0, 1, 1, 0, 1, 600);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule